// File: doc/BRIEF.md
# Burst-Capable Processor Bus Slave

This block is a register-file slave for an asynchronous host bus with Intel-style strobes. The host places a 9-bit register offset on the shared data lines and pulses the address-latch strobe. It then runs read or write cycles with active-low strobes while its chip select is held low. The slave brings every strobe into its own clock domain and captures the offset. It answers each accepted access with a ready handshake: ready drops for a fixed settle time and then returns high.

Burst reads let the host fetch consecutive locations from one address phase. The first read after a latch returns the location at the captured offset. Each later read strobe that arrives with no new latch pulse first advances the held offset by one, wrapping modulo 512, and then fetches that location. Writes store at the held offset and never advance it. The read data leaves the block on a separate output. It comes with an output-enable that the pad ring uses to drive the shared bus. The enable is active only while a selected read strobe is low.

Top module: `burst_bus_slave`

## Requirements
- R1: After reset and while no access is in progress, `rdy_o` is 1 and `bus_oe_o` is 0.
- R2: A rising edge of `ale_i` seen while `cs_n_i` is low captures `bus_i[8:0]` as the held offset.
- R3: The first read after a capture returns the location at the captured offset and does not advance the offset.
- R4: Each later read strobe with no new capture in between advances the offset by one before the fetch, and returns the location at the advanced offset.
- R5: Advancing offset 511 gives offset 0.
- R6: For an accepted read or write, `rdy_o` goes low one cycle after the synchronized strobe edge. It stays low for exactly `SETTLE_CYC` cycles (default 2; values below 2 act as 2) and then returns to 1.
- R7: `bus_oe_o` is 1 from an accepted read until the read strobe or chip select is seen inactive. When `rdy_o` rises during a read, `bus_o` carries the fetched location.
- R8: Read or write strobes made while `cs_n_i` is high are ignored: `rdy_o` stays 1, `bus_oe_o` stays 0, no location is written and the offset does not advance.
- R9: A selected write strobe stores `bus_i` at the held offset, runs the same ready handshake, and leaves the offset unchanged.
- R10: Every strobe passes through a two-flop synchronizer. A falling `rd_n_i` or `wr_n_i` shows as `rdy_o` low on the third clock edge after the input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address-latch strobe, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| bus_i | input | 16 | Incoming side of the shared bus: offset in bits 8:0 during the address phase, write data otherwise |
| bus_o | output | 16 | Read data for the shared bus |
| bus_oe_o | output | 1 | Drive enable for the shared bus pads |
| rdy_o | output | 1 | Ready handshake, low while the slave is not ready |

## Verification
The bound checker covers the following on every clock:
- offset capture on a selected latch edge;
- the hold-versus-advance step on each accepted read, and the hold on a write;
- ready falling after an accepted access, with the length of its low phase bounded by a counter;
- the drive enable dropping after the read strobe or chip select is released.

Some behaviour shows only in the bench scenarios. These are the data returned across a burst, including the wrap from 511 to 0; the exact three-edge latency through the synchronizers; and the proof through later reads that deselected strobes neither wrote a location nor moved the offset.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_WAIT = 2'd1,
    ST_RD_HOLD = 2'd2,
    ST_WR_WAIT = 2'd3
  } bbs_state_e;
endpackage

// File: rtl/bbs_sync.sv
module bbs_sync #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic stage1, stage2;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage1 <= RST_VAL[g];
          stage2 <= RST_VAL[g];
        end else begin
          stage1 <= async_i[g];
          stage2 <= stage1;
        end
      end
      assign sync_o[g] = stage2;
    end
  endgenerate
endmodule

// File: rtl/bbs_strobe_front.sv
module bbs_strobe_front (
  input  logic clk,
  input  logic rst_n,
  input  logic ale_i,
  input  logic cs_n_i,
  input  logic rd_n_i,
  input  logic wr_n_i,
  output logic cs_act,
  output logic ale_rise,
  output logic rd_fall,
  output logic rd_rise,
  output logic wr_fall
);
  // bit order: {wr_n, rd_n, cs_n, ale}
  localparam int         NSTB     = 4;
  localparam logic [3:0] IDLE_LVL = 4'b1110;

  logic [NSTB-1:0] raw, synced, prev;

  assign raw = {wr_n_i, rd_n_i, cs_n_i, ale_i};

  bbs_sync #(.W(NSTB), .RST_VAL(IDLE_LVL)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw),
    .sync_o  (synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE_LVL;
    else        prev <= synced;
  end

  assign cs_act   = !synced[1];
  assign ale_rise =  synced[0] && !prev[0];
  assign rd_fall  = !synced[2] &&  prev[2];
  assign rd_rise  =  synced[2] && !prev[2];
  assign wr_fall  = !synced[3] &&  prev[3];
endmodule

// File: rtl/bbs_access_ctrl.sv
module bbs_access_ctrl #(
  parameter int ADDR_W     = 9,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              ale_rise,
  input  logic              rd_fall,
  input  logic              rd_rise,
  input  logic              wr_fall,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              addr_latch,
  output logic              rd_accept,
  output logic              wr_accept,
  output logic              first_pend,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rdy,
  output logic              drive
);
  import bbs_pkg::*;

  localparam int WAIT_CYC = (SETTLE_CYC < 2) ? 2 : SETTLE_CYC;
  localparam int CNT_W    = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  bbs_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             idle;

  assign idle       = (state == ST_IDLE);
  assign addr_latch = ale_rise && cs_act;
  assign rd_accept  = rd_fall && cs_act && idle && !addr_latch;
  assign wr_accept  = wr_fall && cs_act && idle && !addr_latch && !rd_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      first_pend <= 1'b1;
    end else if (addr_latch) begin
      addr_q     <= addr_in;
      first_pend <= 1'b1;
    end else if (rd_accept) begin
      if (!first_pend) addr_q <= step_addr(addr_q);
      first_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (rd_accept)      state <= ST_RD_WAIT;
          else if (wr_accept) state <= ST_WR_WAIT;
        end
        ST_RD_WAIT: begin
          if (!cs_act || rd_rise)   state <= ST_IDLE;
          else if (cnt == CNT_LAST) state <= ST_RD_HOLD;
          else                      cnt   <= cnt + CNT_W'(1);
        end
        ST_RD_HOLD: begin
          if (!cs_act || rd_rise) state <= ST_IDLE;
        end
        ST_WR_WAIT: begin
          if (cnt == CNT_LAST) state <= ST_IDLE;
          else                 cnt   <= cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rdy   = !(state == ST_RD_WAIT || state == ST_WR_WAIT);
  assign drive =  (state == ST_RD_WAIT || state == ST_RD_HOLD);
endmodule

// File: rtl/bbs_regfile.sv
module bbs_regfile #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rd_word <= mem[addr];
  end

  // Hold the output at zero until reset has been released.
  logic ready_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign rdata = ready_q ? rd_word : '0;
endmodule

// File: rtl/burst_bus_slave.sv
module burst_bus_slave #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              rdy_o
);
  logic              cs_act, ale_rise, rd_fall, rd_rise, wr_fall;
  logic              addr_latch, rd_accept, wr_accept, first_pend;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_src;

  assign addr_src = bus_i[ADDR_W-1:0];

  bbs_strobe_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale_i    (ale_i),
    .cs_n_i   (cs_n_i),
    .rd_n_i   (rd_n_i),
    .wr_n_i   (wr_n_i),
    .cs_act   (cs_act),
    .ale_rise (ale_rise),
    .rd_fall  (rd_fall),
    .rd_rise  (rd_rise),
    .wr_fall  (wr_fall)
  );

  bbs_access_ctrl #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .ale_rise   (ale_rise),
    .rd_fall    (rd_fall),
    .rd_rise    (rd_rise),
    .wr_fall    (wr_fall),
    .addr_in    (addr_src),
    .addr_latch (addr_latch),
    .rd_accept  (rd_accept),
    .wr_accept  (wr_accept),
    .first_pend (first_pend),
    .addr_q     (addr_q),
    .rdy        (rdy_o),
    .drive      (bus_oe_o)
  );

  bbs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_accept),
    .addr  (addr_q),
    .wdata (bus_i),
    .rdata (bus_o)
  );
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
  parameter int ADDR_W     = 9,
  parameter int SETTLE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              rd_rise,
  input logic              addr_latch,
  input logic              rd_accept,
  input logic              wr_accept,
  input logic              first_pend,
  input logic [ADDR_W-1:0] addr_q,
  input logic [ADDR_W-1:0] addr_src,
  input logic              rdy_o,
  input logic              bus_oe_o
);
  localparam int WAIT_CYC = (SETTLE_CYC < 2) ? 2 : SETTLE_CYC;

  logic [15:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_run <= '0;
    else if (rdy_o)           low_run <= '0;
    else if (low_run != '1)   low_run <= low_run + 16'd1;
  end

  assert_latch_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch |=> addr_q == $past(addr_src));

  assert_first_read_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && first_pend) |=> addr_q == $past(addr_q));

  assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && !first_pend) |=> (addr_q - $past(addr_q)) == ADDR_W'(1));

  assert_rdy_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept || wr_accept) |=> !rdy_o);

  assert_rdy_low_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 16'(WAIT_CYC));

  assert_release_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> !bus_oe_o);

  assert_no_drive_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !bus_oe_o);

  assert_write_holds_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> $stable(addr_q));
endmodule

bind burst_bus_slave bbs_checker #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_act     (cs_act),
  .rd_rise    (rd_rise),
  .addr_latch (addr_latch),
  .rd_accept  (rd_accept),
  .wr_accept  (wr_accept),
  .first_pend (first_pend),
  .addr_q     (addr_q),
  .addr_src   (addr_src),
  .rdy_o      (rdy_o),
  .bus_oe_o   (bus_oe_o)
);

// File: tb/burst_bus_slave_tb.sv
module burst_bus_slave_tb_top;
  localparam int SETTLE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out;
  logic        oe, rdy;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  burst_bus_slave #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale_i    (ale),
    .cs_n_i   (cs_n),
    .rd_n_i   (rd_n),
    .wr_n_i   (wr_n),
    .bus_i    (bus_in),
    .bus_o    (bus_out),
    .bus_oe_o (oe),
    .rdy_o    (rdy)
  );

  function automatic logic [15:0] pattern(input int a);
    return 16'((a * 37) ^ 16'h5A3C);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Monitor: on each rising ready during a drive, pop and compare.
  logic prev_rdy = 1'b1;
  always @(negedge clk) begin
    if (rst_n && rdy && !prev_rdy && oe) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected read data", longint'(bus_out), 0);
      end else begin
        logic [15:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_out == e, t, "read data", longint'(bus_out), longint'(e));
      end
    end
    prev_rdy = rdy;
  end

  task automatic latch_addr(input int a);
    @(negedge clk);
    bus_in = 16'(a);
    ale    = 1'b1;
    repeat (4) @(negedge clk);
    ale = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Measure handshake after a strobe fall: R10 latency, R6 low length.
  task automatic handshake(input string what);
    int k;
    int m;
    k = 0;
    do begin @(negedge clk); k++; end while (rdy && k < 20);
    chk(k == 3, "R10", {what, " latency"}, k, 3);
    m = 0;
    while (!rdy && m < 20) begin @(negedge clk); m++; end
    chk(m == SETTLE, "R6", {what, " not-ready length"}, m, SETTLE);
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk);
    bus_in = d;
    wr_n   = 1'b0;
    handshake("write R9");
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_n = 1'b0;
    handshake("read");
    chk(oe == 1'b1, "R7", "drive while strobe low", oe, 1);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(oe == 1'b0, "R7", "release after strobe", oe, 0);
    chk(rdy == 1'b1, "R1", "idle ready", rdy, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R6", "watchdog timeout", 0, 1);
    finish_run();
  end

  initial begin
    int waddr[10];
    waddr = '{16, 17, 18, 19, 20, 21, 510, 511, 0, 1};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b1, "R1", "ready after reset", rdy, 1);
    chk(oe == 1'b0, "R1", "no drive after reset", oe, 0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);

    // Fill locations, each with its own latch (R9: writes do not advance).
    foreach (waddr[i]) begin
      latch_addr(waddr[i]);
      do_write(pattern(waddr[i]));
    end

    // Burst from 0x10: first read holds (R2, R3), later reads advance (R4).
    latch_addr(16);
    do_read(pattern(16), "R3");
    for (int a = 17; a <= 21; a++) do_read(pattern(a), "R4");

    // Burst across the top of the map (R5).
    latch_addr(510);
    do_read(pattern(510), "R2");
    do_read(pattern(511), "R4");
    do_read(pattern(0), "R5");
    do_read(pattern(1), "R5");

    // Deselected strobes are ignored (R8).
    latch_addr(16);
    do_read(pattern(16), "R3");
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_n = 1'b0;
    begin
      bit quiet;
      quiet = 1'b1;
      repeat (8) begin @(negedge clk); if (!rdy || oe) quiet = 1'b0; end
      rd_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_in = 16'hDEAD;
      wr_n   = 1'b0;
      repeat (8) begin @(negedge clk); if (!rdy || oe) quiet = 1'b0; end
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(quiet, "R8", "deselected strobes quiet", !quiet, 0);
    end
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    do_read(pattern(17), "R8");
    latch_addr(16);
    do_read(pattern(16), "R8");

    // Write in a burst then read back at the same offset (R9, R3).
    latch_addr(32);
    do_write(16'hBEEF);
    do_read(16'hBEEF, "R9");
    do_write(16'h1234);
    latch_addr(32);
    do_read(16'h1234, "R9");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule